// File: doc/BRIEF.md
# DPLL Proportional-Integral Loop Filter with Bandwidth Switching

This block is the loop filter of a clock-synchronising digital PLL. On every update strobe it takes a signed phase-error sample and produces a frequency-control word for a numerically controlled oscillator. The word is the sum of a proportional term and an integral term, and the filter keeps the integral term in an accumulator between updates. Gains are powers of two, so the datapath uses shifters and adders and no multipliers.

Two bandwidth codes are supplied: one for acquisition and one for locked operation. With automatic selection enabled, the lock indication picks between them. A damping code sets how far the proportional path sits above the integral path. A code that is not legal for the active bandwidth is replaced by the nearest legal one. The output is saturated to programmable lower and upper frequency bounds, and a flag reports each update that saturated. An optional limit mode freezes the accumulator during such updates, which keeps the loop from winding up and overshooting while it pulls in.

Top module: `dpll_pi_filter`

## Requirements
- R1: After reset, `freqWord` is 0, `limitHit` is 0 and the integral accumulator is 0.
- R2: With `autoBw`=1, an update uses `acqBw` while `locked`=0 and `lockBw` while `locked`=1.
- R3: With `autoBw`=0, every update uses `lockBw`, whatever the value of `locked`.
- R4: With bandwidth code b and legal damping d, the integral step is `phErr`·2^b and the proportional term is `phErr`·2^(b+d). The candidate output is the old accumulator plus the step plus the proportional term.
- R5: The legal damping codes are 1 to 5 when b ≤ 3, and b−2 to 5 when b ≥ 4. A code below the legal range (this includes 0) is applied as the lowest legal code. Codes 6 and 7 are applied as 5.
- R6: `freqWord` takes the candidate clamped to [`fMin`, `fMax`]. `limitHit` is 1 for exactly those updates whose candidate lay strictly outside that range. Both outputs are registered one clock after the strobe.
- R7: With `limInt`=1, the accumulator keeps its value during any update that saturates.
- R8: Otherwise the accumulator becomes the old value plus the step, clamped to [`fMin`, `fMax`]. With `limInt`=0 this happens even in an update that saturates.
- R9: Outputs and accumulator change only on an update strobe. A change of `locked` or of the codes takes effect at the next strobe and leaves the accumulator untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| updStb | input | 1 | Update strobe, one cycle per phase sample |
| phErr | input | ERR_W | Signed phase-error sample |
| locked | input | 1 | Lock indication from the lock detector |
| autoBw | input | 1 | Enable automatic acquisition/locked bandwidth selection |
| limInt | input | 1 | Freeze the integrator on saturating updates |
| acqBw | input | 3 | Acquisition bandwidth code (0 narrowest … 7 widest) |
| lockBw | input | 3 | Locked bandwidth code |
| dampCode | input | 3 | Requested damping code |
| fMin | input | OUT_W | Signed lower frequency bound |
| fMax | input | OUT_W | Signed upper frequency bound |
| freqWord | output | OUT_W | Signed frequency-control word to the NCO |
| limitHit | output | 1 | Last update saturated at a bound |

## Verification
The bench builds the filter with its defaults: a 12-bit error and a 28-bit output. With these widths the largest shift, 12 at code 7 with damping 5, cannot overflow the 30-bit internal sum. The bench narrows the bounds to ±1000 or −500. These small bounds bring saturation, the freeze-versus-clamp difference of the accumulator and the exact-bound non-saturation case within reach in a few strobes. Wide bounds of ±2^26 leave the gain and damping mapping free of saturation.

// File: rtl/lf_pkg.sv
`timescale 1ns/1ps
package lf_pkg;
  localparam int BW_W   = 3;
  localparam int DAMP_W = 3;
  localparam int SH_W   = 4;

  localparam logic [DAMP_W-1:0] DAMP_LO   = 3'd1;
  localparam logic [DAMP_W-1:0] DAMP_HI   = 3'd5;
  // widest bandwidth code that still accepts every damping code
  localparam logic [BW_W-1:0]   BW_ALLD   = 3'd3;
  localparam logic [BW_W-1:0]   BW_DOFS   = 3'd2;

  typedef struct packed {
    logic            update;
    logic            freeze;
    logic [SH_W-1:0] iShift;
    logic [SH_W-1:0] pShift;
  } ctrl_t;
endpackage

// File: rtl/lf_ctrl.sv
`timescale 1ns/1ps
module lf_ctrl
  import lf_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              updStb,
  input  logic              locked,
  input  logic              autoBw,
  input  logic              limInt,
  input  logic [BW_W-1:0]   acqBw,
  input  logic [BW_W-1:0]   lockBw,
  input  logic [DAMP_W-1:0] dampCode,
  output ctrl_t             ctl
);
  logic [BW_W-1:0]   bwSel;
  logic [DAMP_W-1:0] dampFloor;
  logic [DAMP_W-1:0] dampEff;

  // bandwidth choice: acquisition code only while hunting with auto mode on
  always_comb begin
    bwSel = (autoBw && !locked) ? acqBw : lockBw;
  end

  // damping legalisation: pull an illegal request to the nearest legal code
  always_comb begin
    dampFloor = (bwSel <= BW_ALLD) ? DAMP_LO : DAMP_W'(bwSel - BW_DOFS);
    if (dampCode < dampFloor)     dampEff = dampFloor;
    else if (dampCode > DAMP_HI)  dampEff = DAMP_HI;
    else                          dampEff = dampCode;
  end

  always_comb begin
    ctl.update = updStb;
    ctl.freeze = limInt;
    ctl.iShift = SH_W'(bwSel);
    ctl.pShift = SH_W'(bwSel) + SH_W'(dampEff);
  end

  // R5
  damp_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((ctl.pShift - ctl.iShift) >= SH_W'(1)) && ((ctl.pShift - ctl.iShift) <= SH_W'(5)));

  // R5
  damp_floor_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.iShift >= SH_W'(4)) |-> ((ctl.pShift - ctl.iShift) >= (ctl.iShift - SH_W'(2))));

  // R3
  manual_bw_chk: assert property (@(posedge clk) disable iff (!rstN)
    !autoBw |-> (ctl.iShift == SH_W'(lockBw)));
endmodule

// File: rtl/lf_datapath.sv
`timescale 1ns/1ps
module lf_datapath
  import lf_pkg::*;
#(
  parameter int ERR_W = 12,
  parameter int OUT_W = 28
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctrl_t                   ctl,
  input  logic signed [ERR_W-1:0] phErr,
  input  logic signed [OUT_W-1:0] fMin,
  input  logic signed [OUT_W-1:0] fMax,
  output logic signed [OUT_W-1:0] freqWord,
  output logic                    limitHit
);
  localparam int SUM_W = OUT_W + 2;

  logic signed [OUT_W-1:0] integ;
  logic signed [SUM_W-1:0] errExt, iStep, pTerm, integSum, cand, loExt, hiExt;
  logic                    candHi, candLo, candSat;

  function automatic logic signed [OUT_W-1:0] clampOut(
    input logic signed [SUM_W-1:0] v,
    input logic signed [SUM_W-1:0] lo,
    input logic signed [SUM_W-1:0] hi);
    if (v > hi)      return OUT_W'(hi);
    else if (v < lo) return OUT_W'(lo);
    else             return OUT_W'(v);
  endfunction

  always_comb begin
    errExt   = SUM_W'(phErr);
    loExt    = SUM_W'(fMin);
    hiExt    = SUM_W'(fMax);
    iStep    = errExt <<< ctl.iShift;
    pTerm    = errExt <<< ctl.pShift;
    integSum = SUM_W'(integ) + iStep;
    cand     = integSum + pTerm;
    candHi   = cand > hiExt;
    candLo   = cand < loExt;
    candSat  = candHi || candLo;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      integ    <= '0;
      freqWord <= '0;
      limitHit <= 1'b0;
    end else if (ctl.update) begin
      freqWord <= clampOut(cand, loExt, hiExt);
      limitHit <= candSat;
      if (!(ctl.freeze && candSat)) integ <= clampOut(integSum, loExt, hiExt);
    end
  end

  // R6
  out_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.update |=> (freqWord <= $past(fMax)) && (freqWord >= $past(fMin)));

  // R6
  flag_at_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.update |=> (!limitHit || freqWord == $past(fMax) || freqWord == $past(fMin)));

  // R7
  integ_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.update && ctl.freeze && candSat) |=> (integ == $past(integ)));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.update |=> $stable(freqWord) && $stable(limitHit) && $stable(integ));
endmodule

// File: rtl/dpll_pi_filter.sv
`timescale 1ns/1ps
module dpll_pi_filter
  import lf_pkg::*;
#(
  parameter int ERR_W = 12,
  parameter int OUT_W = 28
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    updStb,
  input  logic signed [ERR_W-1:0] phErr,
  input  logic                    locked,
  input  logic                    autoBw,
  input  logic                    limInt,
  input  logic [2:0]              acqBw,
  input  logic [2:0]              lockBw,
  input  logic [2:0]              dampCode,
  input  logic signed [OUT_W-1:0] fMin,
  input  logic signed [OUT_W-1:0] fMax,
  output logic signed [OUT_W-1:0] freqWord,
  output logic                    limitHit
);
  ctrl_t ctl;

  lf_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .updStb   (updStb),
    .locked   (locked),
    .autoBw   (autoBw),
    .limInt   (limInt),
    .acqBw    (acqBw),
    .lockBw   (lockBw),
    .dampCode (dampCode),
    .ctl      (ctl)
  );

  lf_datapath #(.ERR_W(ERR_W), .OUT_W(OUT_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .phErr    (phErr),
    .fMin     (fMin),
    .fMax     (fMax),
    .freqWord (freqWord),
    .limitHit (limitHit)
  );
endmodule

// File: tb/dpll_pi_filter_test.sv
`timescale 1ns/1ps
module dpll_pi_filter_test;
  localparam int EW = 12;
  localparam int OW = 28;

  logic clk = 1'b0;
  logic rstN, updStb, locked, autoBw, limInt;
  logic signed [EW-1:0] phErr;
  logic [2:0] acqBw, lockBw, dampCode;
  logic signed [OW-1:0] fMin, fMax, freqWord;
  logic limitHit;

  int checks = 0;
  int errors = 0;
  longint mInteg = 0;

  always #2.5 clk = ~clk;

  dpll_pi_filter #(.ERR_W(EW), .OUT_W(OW)) uut (
    .clk(clk), .rstN(rstN), .updStb(updStb), .phErr(phErr), .locked(locked),
    .autoBw(autoBw), .limInt(limInt), .acqBw(acqBw), .lockBw(lockBw),
    .dampCode(dampCode), .fMin(fMin), .fMax(fMax), .freqWord(freqWord),
    .limitHit(limitHit)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int legalD(input int b, input int d);
    int mn;
    mn = (b <= 3) ? 1 : b - 2;
    if (d < mn) return mn;
    if (d > 5)  return 5;
    return d;
  endfunction

  function automatic longint clampL(input longint v);
    if (v > longint'(fMax)) return longint'(fMax);
    if (v < longint'(fMin)) return longint'(fMin);
    return v;
  endfunction

  // model one update from the requirements, strobe it, check both outputs
  task automatic doUpdate(input int e, input string tag);
    int b, d;
    longint iStep, prop, cand, expF;
    bit sat;
    b     = (autoBw && !locked) ? int'(acqBw) : int'(lockBw);
    d     = legalD(b, int'(dampCode));
    iStep = longint'(e) <<< b;
    prop  = longint'(e) <<< (b + d);
    cand  = mInteg + iStep + prop;
    sat   = (cand > longint'(fMax)) || (cand < longint'(fMin));
    expF  = clampL(cand);
    if (!(limInt && sat)) mInteg = clampL(mInteg + iStep);
    phErr  = EW'(e);
    updStb = 1'b1;
    @(negedge clk);
    updStb = 1'b0;
    check({tag, " freq"}, longint'(freqWord), expF);
    check({tag, " limit"}, longint'(limitHit), longint'(sat));
  endtask

  task automatic doReset();
    rstN = 1'b0;
    updStb = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    mInteg = 0;
  endtask

  task automatic wideBounds();
    fMin = -(OW'(1) <<< 26);
    fMax =  (OW'(1) <<< 26);
  endtask

  task automatic t_reset();
    doReset();
    check("R1 reset freq", longint'(freqWord), 0);
    check("R1 reset limit", longint'(limitHit), 0);
    // accumulator at zero shows as freq 0 after a zero-error update
    doUpdate(0, "R1 reset integ");
  endtask

  task automatic t_gain();
    autoBw = 1'b0; lockBw = 3'd2; dampCode = 3'd1; limInt = 1'b0;
    doUpdate(3, "R4 gain pos");
    check("R4 gain literal", longint'(freqWord), 36);
    doUpdate(-5, "R4 gain neg");
    check("R4 gain literal neg", longint'(freqWord), -48);
  endtask

  task automatic t_auto();
    autoBw = 1'b1; locked = 1'b0; acqBw = 3'd5; lockBw = 3'd1; dampCode = 3'd5;
    doUpdate(2, "R2 auto acquiring");
    locked = 1'b1;
    @(negedge clk);
    check("R9 lock change no step", longint'(freqWord), mInteg + ((longint'(2) <<< 5) <<< 5));
    doUpdate(2, "R2 auto locked");
    doUpdate(-3, "R2 auto locked neg");
  endtask

  task automatic t_manual();
    autoBw = 1'b0; locked = 1'b0; acqBw = 3'd6; lockBw = 3'd1; dampCode = 3'd3;
    doUpdate(1, "R3 manual unlocked");
    locked = 1'b1;
    doUpdate(-1, "R3 manual locked");
  endtask

  task automatic t_damp();
    autoBw = 1'b0;
    lockBw = 3'd7; dampCode = 3'd1; doUpdate(1, "R5 b7 d1 to 5");
    lockBw = 3'd4; dampCode = 3'd0; doUpdate(-1, "R5 b4 d0 to 2");
    lockBw = 3'd1; dampCode = 3'd7; doUpdate(1, "R5 b1 d7 to 5");
    lockBw = 3'd5; dampCode = 3'd4; doUpdate(-1, "R5 b5 d4 legal");
    lockBw = 3'd6; dampCode = 3'd2; doUpdate(1, "R5 b6 d2 to 4");
    lockBw = 3'd0; dampCode = 3'd0; doUpdate(-1, "R5 b0 d0 to 1");
  endtask

  task automatic satSeq(input string tag);
    fMin = -OW'(1000); fMax = OW'(1000);
    autoBw = 1'b0; lockBw = 3'd0; dampCode = 3'd3;
    doUpdate(100, {tag, " below bound"});
    doUpdate(100, {tag, " exactly at bound"});
    doUpdate(101, {tag, " over bound"});
    doUpdate(0, {tag, " accumulator after"});
  endtask

  task automatic t_satFreeze();
    doReset();
    limInt = 1'b1;
    satSeq("R7 freeze");
    check("R7 frozen accumulator", longint'(freqWord), 200);
  endtask

  task automatic t_satNoFreeze();
    doReset();
    limInt = 1'b0;
    satSeq("R8 nofreeze");
    check("R8 accumulator moved", longint'(freqWord), 301);
    lockBw = 3'd4; dampCode = 3'd2;
    doUpdate(100, "R8 accumulator clamped");
    doUpdate(0, "R8 clamp held");
    check("R8 accumulator at bound", longint'(freqWord), 1000);
  endtask

  task automatic t_satLow();
    doReset();
    limInt = 1'b1; fMin = -OW'(500); fMax = OW'(1000);
    autoBw = 1'b0; lockBw = 3'd0; dampCode = 3'd3;
    doUpdate(-200, "R6 low saturation");
    check("R6 low bound value", longint'(freqWord), -500);
    doUpdate(0, "R7 low freeze");
  endtask

  task automatic t_hold();
    logic signed [OW-1:0] fw;
    logic lh;
    wideBounds();
    limInt = 1'b0; autoBw = 1'b1; locked = 1'b1; lockBw = 3'd2; dampCode = 3'd2;
    doUpdate(7, "R9 setup");
    fw = freqWord; lh = limitHit;
    phErr = EW'(-300); locked = 1'b0; acqBw = 3'd7; dampCode = 3'd5;
    repeat (3) @(negedge clk);
    check("R9 hold freq", longint'(freqWord), longint'(fw));
    check("R9 hold limit", longint'(limitHit), longint'(lh));
    doUpdate(0, "R9 accumulator kept");
  endtask

  initial begin
    rstN = 1'b0; updStb = 1'b0; phErr = '0; locked = 1'b0; autoBw = 1'b0;
    limInt = 1'b0; acqBw = '0; lockBw = '0; dampCode = 3'd1;
    wideBounds();
    @(negedge clk);
    t_reset();
    t_gain();
    t_auto();
    t_manual();
    t_damp();
    t_satFreeze();
    t_satNoFreeze();
    t_satLow();
    t_hold();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule